// File: doc/BRIEF.md
# Triggered Sample Capture Logger

The block records one fixed-length burst of 48-bit samples into an internal RAM. A control write with its go bit set arms a capture. From then on, every strobe on `sample_en` stores one sample at the next RAM location, starting at location 0. The burst ends by itself once every location has been written. The start request clears itself: status bit 0 reads 1 only while the capture runs. Status bit 1 is set when the burst completes. The start command latches where the samples come from. The source is either the position word or one of several ADC monitor channels, sign-extended to 48 bits.

A packetiser fetches stored data in groups of `GROUP_LEN` consecutive samples. It names a group index on a valid/ready request channel. The block answers on a byte stream with valid/ready flow control. Each sample is sent as six bytes, least significant byte first, and samples go out in ascending order. `out_last` marks the final byte of the group.

The request channel is ready only while no group is being sent, so a request waits until the previous group finishes. The byte stream may be held off for any number of cycles by dropping `out_ready`, and the byte on offer stays stable while it waits. Readout never stalls capture. A location not written since the most recent start reads back as zero. This includes a location being written in the same cycle as its fetch.

The capacity is `GROUP_LEN * NUM_GROUPS` samples. A full-size instance uses 8 x 3584, which is 28672 samples. `GROUP_LEN` must be a power of two.

Top module: `capture_logger`

## Requirements
- R1: After reset, `stat` is 2'b00, `out_valid` is 0, `req_ready` is 1, and every group reads back as all-zero bytes.
- R2: `stat[0]` is the running flag and `stat[1]` is the done flag. A cycle with `cmd_we`=1 and `cmd_go`=1 while not running makes `stat` equal 2'b01 after the next edge. This clears done and restarts the write location at 0.
- R3: A start command while a capture is running is ignored: the write location, the latched source and the end of the burst are unchanged.
- R4: While running, each `sample_en` cycle stores one sample at the next location (0, 1, 2, ...). `sample_en` while not running stores nothing.
- R5: The strobe that writes the last location sets `stat` to 2'b10 after that edge. Later strobes change no stored sample, and done stays set until the next accepted start.
- R6: With `src_pos`=1 at start the samples are `pos_data`. With `src_pos`=0 they are ADC channel `adc_sel` (bits `[c*ADC_W +: ADC_W]` of `adc_mon`), sign-extended to 48 bits. Both selects are taken only at an accepted start.
- R7: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. It returns samples g*GROUP_LEN .. g*GROUP_LEN+GROUP_LEN-1 in order, six bytes each, least significant byte first. `out_last` is 1 exactly on the last byte. `req_ready` is 0 while bytes are pending.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_last` hold and `out_valid` stays 1.
- R9: A sample whose location was not written since the last start reads back as zero. This covers a location written in the same cycle as its fetch and any group index of `NUM_GROUPS` or more.
- R10: Readout during a running capture does not delay it. With one strobe per cycle, done is set after the `GROUP_LEN*NUM_GROUPS`-th strobe. Every sample already written when a request is accepted reads back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Control write strobe |
| cmd_go | input | 1 | Control write data bit 0 (start) |
| src_pos | input | 1 | 1 selects position data, 0 an ADC channel |
| adc_sel | input | $clog2(NUM_ADC) | ADC monitor channel select |
| adc_mon | input | NUM_ADC*ADC_W | Packed ADC monitor channels, signed |
| pos_data | input | SAMPLE_W | Position value |
| sample_en | input | 1 | Sample strobe |
| stat | output | 2 | {done, running} |
| req_valid | input | 1 | Group request valid |
| req_ready | output | 1 | Group request ready |
| req_group | input | $clog2(NUM_GROUPS) | Group index |
| out_valid | output | 1 | Byte valid |
| out_ready | input | 1 | Byte ready |
| out_data | output | 8 | Sample byte |
| out_last | output | 1 | Last byte of the group |

## Verification
Two functions can fall in the same cycle: a capture write at location N and a readout fetch of that same location or one just behind it. The bench provokes this by running a full capture with one strobe per cycle. While that capture runs, it requests every group in turn under several back-pressure patterns. Each returned sample must equal its recorded value or zero, and must be exact if it was written before the request was accepted. Done must still arrive right after the last strobe.

// File: rtl/lgr_pkg.sv
package lgr_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_LOAD  = 2'd2,
    RD_SEND  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/lgr_src_mux.sv
module lgr_src_mux #(
  parameter int SAMPLE_W = 48,
  parameter int NUM_ADC  = 4,
  parameter int ADC_W    = 16,
  localparam int SW = $clog2(NUM_ADC)
) (
  input  logic [NUM_ADC*ADC_W-1:0] adc_mon,
  input  logic [SW-1:0]            adc_sel,
  input  logic                     use_pos,
  input  logic [SAMPLE_W-1:0]      pos_data,
  output logic [SAMPLE_W-1:0]      sample
);
  logic [SAMPLE_W-1:0] ext [NUM_ADC];

  for (genvar c = 0; c < NUM_ADC; c++) begin : g_ext
    assign ext[c] = {{(SAMPLE_W-ADC_W){adc_mon[c*ADC_W+ADC_W-1]}},
                     adc_mon[c*ADC_W +: ADC_W]};
  end

  assign sample = use_pos ? pos_data : ext[adc_sel];
endmodule

// File: rtl/lgr_capture_ctl.sv
module lgr_capture_ctl #(
  parameter int DEPTH = 384,
  parameter int SW    = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int FW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          cmd_go,
  input  logic          src_pos,
  input  logic [SW-1:0] adc_sel,
  input  logic          sample_en,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] fill,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          use_pos_q,
  output logic [SW-1:0] adc_sel_q
);
  logic start_ok;
  logic last_wr;

  assign start_ok = cmd_we & cmd_go & ~busy;
  assign wr_en    = busy & sample_en;
  assign wr_addr  = fill[AW-1:0];
  assign last_wr  = (fill == FW'(DEPTH-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      fill      <= '0;
      use_pos_q <= 1'b0;
      adc_sel_q <= '0;
    end else if (start_ok) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      fill      <= '0;
      use_pos_q <= src_pos;
      adc_sel_q <= adc_sel;
    end else if (wr_en) begin
      fill <= fill + FW'(1);
      if (last_wr) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_go && !busy) |=> (busy && !done && fill == '0));
  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sample_en && fill < FW'(DEPTH-1)) |=> (busy && fill == $past(fill) + FW'(1)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !(cmd_we && cmd_go)) |=> $stable(fill));
  assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(cmd_we && cmd_go)) |=> (done && $stable(fill)));
endmodule

// File: rtl/lgr_ram.sv
module lgr_ram #(
  parameter int W     = 48,
  parameter int DEPTH = 384,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/lgr_readout.sv
module lgr_readout
  import lgr_pkg::*;
#(
  parameter int SAMPLE_W   = 48,
  parameter int GROUP_LEN  = 8,
  parameter int NUM_GROUPS = 48,
  localparam int DEPTH  = GROUP_LEN * NUM_GROUPS,
  localparam int AW     = $clog2(DEPTH),
  localparam int FW     = AW + 1,
  localparam int GW     = $clog2(NUM_GROUPS),
  localparam int LW     = $clog2(GROUP_LEN),
  localparam int NBYTES = SAMPLE_W / 8,
  localparam int BW     = $clog2(NBYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [GW-1:0]       req_group,
  input  logic [FW-1:0]       fill,
  output logic                rd_en,
  output logic [AW-1:0]       rd_addr,
  input  logic [SAMPLE_W-1:0] rd_q,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [7:0]          out_data,
  output logic                out_last
);
  rd_state_e           state;
  logic [GW-1:0]       grp_q;
  logic [LW-1:0]       idx_q;
  logic [BW-1:0]       bcnt_q;
  logic [SAMPLE_W-1:0] shreg_q;
  logic                hit_q;
  logic [FW-1:0]       saddr;
  logic                hit;
  logic                last_byte;
  logic                last_idx;

  // location index of the sample being fetched; out-of-range groups land at or above DEPTH
  assign saddr     = FW'({grp_q, idx_q});
  assign hit       = (saddr < fill);
  assign rd_en     = (state == RD_ISSUE) && hit;
  assign rd_addr   = saddr[AW-1:0];
  assign req_ready = (state == RD_IDLE);
  assign out_valid = (state == RD_SEND);
  assign out_data  = shreg_q[7:0];
  assign last_byte = (bcnt_q == BW'(NBYTES-1));
  assign last_idx  = (idx_q == LW'(GROUP_LEN-1));
  assign out_last  = out_valid && last_byte && last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RD_IDLE;
      grp_q   <= '0;
      idx_q   <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      case (state)
        RD_IDLE: if (req_valid) begin
          grp_q <= req_group;
          idx_q <= '0;
          state <= RD_ISSUE;
        end
        RD_ISSUE: begin
          hit_q <= hit;
          state <= RD_LOAD;
        end
        RD_LOAD: begin
          shreg_q <= hit_q ? rd_q : '0;
          bcnt_q  <= '0;
          state   <= RD_SEND;
        end
        RD_SEND: if (out_ready) begin
          shreg_q <= shreg_q >> 8;
          if (last_byte) begin
            if (last_idx) begin
              state <= RD_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              state <= RD_ISSUE;
            end
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  assert_noreq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);
  assert_endgrp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> req_ready);
  assert_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (FW'(rd_addr) < fill));
endmodule

// File: rtl/capture_logger.sv
module capture_logger #(
  parameter int SAMPLE_W   = 48,
  parameter int GROUP_LEN  = 8,
  parameter int NUM_GROUPS = 48,
  parameter int NUM_ADC    = 4,
  parameter int ADC_W      = 16,
  localparam int DEPTH = GROUP_LEN * NUM_GROUPS,
  localparam int AW    = $clog2(DEPTH),
  localparam int FW    = AW + 1,
  localparam int GW    = $clog2(NUM_GROUPS),
  localparam int SW    = $clog2(NUM_ADC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_we,
  input  logic                     cmd_go,
  input  logic                     src_pos,
  input  logic [SW-1:0]            adc_sel,
  input  logic [NUM_ADC*ADC_W-1:0] adc_mon,
  input  logic [SAMPLE_W-1:0]      pos_data,
  input  logic                     sample_en,
  output logic [1:0]               stat,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [GW-1:0]            req_group,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [7:0]               out_data,
  output logic                     out_last
);
  logic                busy, done;
  logic [FW-1:0]       fill;
  logic                wr_en;
  logic [AW-1:0]       wr_addr;
  logic                use_pos_q;
  logic [SW-1:0]       adc_sel_q;
  logic [SAMPLE_W-1:0] sample;
  logic                rd_en;
  logic [AW-1:0]       rd_addr;
  logic [SAMPLE_W-1:0] rd_q;

  assign stat = {done, busy};

  lgr_capture_ctl #(.DEPTH(DEPTH), .SW(SW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_go(cmd_go),
    .src_pos(src_pos), .adc_sel(adc_sel), .sample_en(sample_en),
    .busy(busy), .done(done), .fill(fill), .wr_en(wr_en), .wr_addr(wr_addr),
    .use_pos_q(use_pos_q), .adc_sel_q(adc_sel_q)
  );

  lgr_src_mux #(.SAMPLE_W(SAMPLE_W), .NUM_ADC(NUM_ADC), .ADC_W(ADC_W)) u_mux (
    .adc_mon(adc_mon), .adc_sel(adc_sel_q), .use_pos(use_pos_q),
    .pos_data(pos_data), .sample(sample)
  );

  lgr_ram #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(sample),
    .re(rd_en), .raddr(rd_addr), .q(rd_q)
  );

  lgr_readout #(.SAMPLE_W(SAMPLE_W), .GROUP_LEN(GROUP_LEN), .NUM_GROUPS(NUM_GROUPS)) u_rd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_group(req_group), .fill(fill), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_q(rd_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  assert_nowrite_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat[0] && !(cmd_we && cmd_go)) |=> $stable(fill));
endmodule

// File: tb/sim_capture_logger.sv
module sim_capture_logger;
  localparam int GL = 8, NG = 6, NA = 4, AWD = 12, SMW = 48, DEPTH = GL * NG, NB = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_we = 0, cmd_go = 0, src_pos = 0, sample_en = 0;
  logic [1:0] adc_sel = 0;
  logic [NA*AWD-1:0] adc_mon = '0;
  logic [SMW-1:0] pos_data = '0;
  logic [1:0] stat;
  logic req_valid = 0, req_ready, out_valid, out_ready = 0, out_last;
  logic [2:0] req_group = 0;
  logic [7:0] out_data;

  capture_logger #(.SAMPLE_W(SMW), .GROUP_LEN(GL), .NUM_GROUPS(NG), .NUM_ADC(NA), .ADC_W(AWD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_go(cmd_go), .src_pos(src_pos),
    .adc_sel(adc_sel), .adc_mon(adc_mon), .pos_data(pos_data), .sample_en(sample_en),
    .stat(stat), .req_valid(req_valid), .req_ready(req_ready), .req_group(req_group),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0, errors = 0, kseq = 0, exp_fill = 0, cap_ch = 0;
  bit finished = 0, exp_busy = 0, cap_pos = 0;
  logic [SMW-1:0] exp_mem [DEPTH];
  logic [SMW-1:0] rx [GL];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [AWD-1:0] adc_val(int k, int c);
    return AWD'((k * 37 + c * 419 + 2000) % 4096);
  endfunction

  function automatic logic [SMW-1:0] pos_val(int k);
    return SMW'(k) * 48'h0001_0203_0405 + 48'h8000_0000_00F0;
  endfunction

  function automatic logic [SMW-1:0] exp_sample(bit p, int c, int k);
    logic [AWD-1:0] v;
    v = adc_val(k, c);
    return p ? pos_val(k) : {{(SMW-AWD){v[AWD-1]}}, v};
  endfunction

  // n strobes, each followed by gap idle cycles; expected store tracked per R4/R5
  task automatic strobe_run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pos_data = pos_val(kseq);
      for (int c = 0; c < NA; c++) adc_mon[c*AWD +: AWD] = adc_val(kseq, c);
      sample_en = 1'b1;
      if (exp_busy) begin
        exp_mem[exp_fill] = exp_sample(cap_pos, cap_ch, kseq);
        exp_fill++;
        if (exp_fill == DEPTH) exp_busy = 0;
      end
      kseq++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        sample_en = 1'b0;
      end
    end
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic send_cmd(input bit p, input int ch);
    @(negedge clk);
    cmd_we = 1; cmd_go = 1; src_pos = p; adc_sel = 2'(ch);
    @(negedge clk);
    cmd_we = 0; cmd_go = 0;
  endtask

  task automatic do_start(input bit p, input int ch);
    send_cmd(p, ch);
    cap_pos = p; cap_ch = ch; exp_fill = 0; exp_busy = 1;
    chk(stat == 2'b01, "R2", "stat after start", 64'(stat), 64'h1);
  endtask

  task automatic read_group(input int g, input logic [15:0] pat, output int snap);
    int nb, cyc;
    bit held_v, held_l;
    logic [7:0] held_d;
    bit rdy;
    nb = 0; cyc = 0; held_v = 0; held_l = 0; held_d = '0;
    @(negedge clk);
    req_valid = 1; req_group = 3'(g);
    while (!req_ready) @(negedge clk);
    snap = exp_fill;
    @(negedge clk);
    req_valid = 0;
    while (nb < GL * NB) begin
      if (held_v)
        chk(out_valid && out_data == held_d && out_last == held_l, "R8",
            "byte held under back-pressure", 64'(out_data), 64'(held_d));
      rdy = pat[cyc % 16];
      out_ready = rdy;
      if (out_valid && rdy) begin
        rx[nb / NB][8*(nb % NB) +: 8] = out_data;
        if (out_last != (nb == GL*NB-1))
          chk(0, "R7", "out_last position", 64'(out_last), 64'(nb == GL*NB-1));
        nb++;
        held_v = 0;
      end else begin
        held_v = out_valid; held_d = out_data; held_l = out_last;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 0;
    chk(req_ready && !out_valid, "R7", "ready after group", 64'(req_ready), 64'h1);
  endtask

  // exact check against the expected memory; locations at or above the fill read zero
  task automatic verify_group(input int g, input string req);
    for (int i = 0; i < GL; i++) begin
      int a;
      logic [SMW-1:0] e;
      a = g * GL + i;
      e = (a < exp_fill) ? exp_mem[a] : '0;
      chk(rx[i] == e, req, $sformatf("group %0d sample %0d", g, i), 64'(rx[i]), 64'(e));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(stat == 2'b00, "R1", "stat reset", 64'(stat), 64'h0);
    chk(!out_valid, "R1", "out_valid reset", 64'(out_valid), 64'h0);
    chk(req_ready, "R1", "req_ready reset", 64'(req_ready), 64'h1);
    read_group(0, 16'hFFFF, snap);
    verify_group(0, "R1");

    // capture 1: position source, ignored restart mid-run (R3), source change ignored (R6)
    do_start(1, 0);
    strobe_run(20, 1);
    send_cmd(0, 3);
    chk(stat == 2'b01, "R3", "stat after ignored start", 64'(stat), 64'h1);
    strobe_run(DEPTH - 21, 2);
    chk(stat == 2'b01, "R5", "still running before last", 64'(stat), 64'h1);
    strobe_run(1, 0);
    chk(stat == 2'b10, "R5", "done after last strobe", 64'(stat), 64'h2);
    strobe_run(5, 0);
    chk(stat == 2'b10, "R5", "done sticky", 64'(stat), 64'h2);
    for (int g = 0; g < 8; g++) begin
      logic [15:0] pats [4];
      pats[0] = 16'hFFFF; pats[1] = 16'h5555; pats[2] = 16'h0F0F; pats[3] = 16'hB6D9;
      read_group(g, pats[g % 4], snap);
      verify_group(g, (g < NG) ? "R6" : "R9");
    end

    // capture 2: idle strobes ignored (R4), partial readout (R9), ADC sign extension (R6)
    strobe_run(3, 0);
    chk(stat == 2'b10, "R4", "idle strobes leave done", 64'(stat), 64'h2);
    do_start(0, 2);
    strobe_run(10, 0);
    read_group(0, 16'hF3F3, snap);
    verify_group(0, "R4");
    read_group(1, 16'h7777, snap);
    verify_group(1, "R9");
    read_group(7, 16'hFFFF, snap);
    verify_group(7, "R9");
    strobe_run(DEPTH - 10, 0);
    chk(stat == 2'b10, "R5", "done capture 2", 64'(stat), 64'h2);
    for (int g = 0; g < NG; g++) begin
      read_group(g, 16'hEDB7, snap);
      verify_group(g, "R6");
    end

    // capture 3: back-to-back strobes with concurrent readout (R10)
    do_start(0, 3);
    fork
      begin
        strobe_run(DEPTH, 0);
        chk(stat == 2'b10, "R10", "done on last back-to-back strobe", 64'(stat), 64'h2);
      end
      begin
        for (int g = 0; g < NG; g++) begin
          int s;
          read_group(g, (g % 2) ? 16'hFFFF : 16'h6DB6, s);
          for (int i = 0; i < GL; i++) begin
            int a;
            a = g * GL + i;
            if (a + 1 < s)
              chk(rx[i] == exp_mem[a], "R10", $sformatf("written sample %0d", a),
                  64'(rx[i]), 64'(exp_mem[a]));
            else
              chk(rx[i] == exp_mem[a] || rx[i] == '0, "R9",
                  $sformatf("in-flight sample %0d", a), 64'(rx[i]), 64'(exp_mem[a]));
          end
        end
      end
    join
    for (int g = 0; g < NG; g++) begin
      read_group(g, 16'hFFFF, snap);
      verify_group(g, "R10");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule